// File: doc/BRIEF.md
# Serial Bit-Clock Generator

This block produces the bit-timing strobes for the transmit and receive halves of an asynchronous/synchronous serial port. Each direction keeps its own phase reference. When a direction is started, its divider phase (or its external edge counter) is reloaded, and the other direction is left alone. The transmit side emits a one-cycle `tx_shift_o` strobe on each falling edge of its bit clock. The receive side emits a one-cycle `rx_sample_o` strobe on each rising edge of its bit clock.

There are four clocking modes: internal asynchronous with the clock pin released, internal asynchronous with the clock pin driven, internal synchronous with the clock pin driven, and external asynchronous with a 16x clock on `ext_clk_i`. The shift registers, framing, parity and interrupts are outside this block. The mode must be held steady while a direction is active.

Top module: `sci_bitclk_gen`

## Requirements
- R1: After reset both strobes are low and the clock pin output is high. Both internal clock levels are high, both external counters are 0, and no direction is active.
- R2: In internal asynchronous modes (mode 0 or 1), the bit period is P = 16·D system clocks, with half H = 8·D. If a direction starts at edge E0, its clock is low in the cycles following E0..E(H-1) of each period and high for the rest. The transmit strobe follows E0, E(P), E(2P) and so on. The receive strobe follows E(H), E(H+P) and so on.
- R3: In internal synchronous mode (mode 2), P = 2·D and H = D, with the same strobe placement as R2.
- R4: A start request for a direction that is already active is ignored, and that direction keeps its phase.
- R5: The two directions have independent phases. Starting one does not move the strobes of the other, and a transmit strobe and a receive strobe may occur in the same cycle.
- R6: In external mode (mode 3), `ext_clk_i` passes through a two-flop synchronizer, and each rising edge advances the counter of every active direction modulo 16. Starting a direction presets its counter to 15. The transmit strobe fires when the counter wraps to 0, and the receive strobe fires when it reaches 8. Edges seen by an inactive direction produce no strobe.
- R7: In modes 0 and 3, `clk_pin_oe_o` is low and `clk_pin_o` is high. In mode 1, the pin is driven with the transmit clock while transmit is active, and otherwise with the receive clock. In mode 2, the pin is driven with the transmit clock.
- R8: A stop request ends a direction's strobes from the next cycle and returns its clock level high. Stop takes priority over a simultaneous start. In mode 2 the pin therefore rests high once transmit is stopped.
- R9: The divider D is taken from `div_i` only at the start of a direction; later changes have no effect until the next start. A value of 0 acts as 1.
- R10: Each strobe lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 int async, 1 int async + pin, 2 int sync + pin, 3 external 16x |
| div_i | input | DIV_W | Bit-clock divider D |
| tx_start_i | input | 1 | Start the transmit bit clock |
| tx_stop_i | input | 1 | Stop the transmit bit clock |
| rx_start_i | input | 1 | Start the receive bit clock |
| rx_stop_i | input | 1 | Stop the receive bit clock |
| ext_clk_i | input | 1 | External 16x clock, asynchronous |
| tx_shift_o | output | 1 | Transmit shift strobe |
| rx_sample_o | output | 1 | Receive sample strobe |
| clk_pin_o | output | 1 | Clock pin level |
| clk_pin_oe_o | output | 1 | Clock pin drive enable |

## Verification
The transmit shift strobe and the receive sample strobe can land in the same cycle. The bench provokes this by starting receive first and transmit exactly H cycles later, so the receive clock rises as the transmit start produces its falling edge. It then requires both strobes high in that cycle and again one period later. A second collision, start and stop in the same cycle, is judged by requiring silence on the strobe.

// File: rtl/sci_clk_pkg.sv
package sci_clk_pkg;
  typedef enum logic [1:0] {
    MODE_INT_ASYNC     = 2'd0,
    MODE_INT_ASYNC_OUT = 2'd1,
    MODE_INT_SYNC_OUT  = 2'd2,
    MODE_EXT_ASYNC     = 2'd3
  } sci_mode_e;
endpackage

// File: rtl/sci_edge_sync.sv
module sci_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/sci_dir_clk.sv
module sci_dir_clk #(
  parameter int DIV_W       = 16,
  parameter int EXT_MOD     = 16,
  parameter bit FALL_STROBE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_mode_i,
  input  logic             sync_mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_rise_i,
  output logic             active_o,
  output logic             lvl_o,
  output logic             strobe_o
);
  localparam int EW     = $clog2(EXT_MOD);
  localparam int OVS_SH = EW - 1;
  localparam int HW     = DIV_W + OVS_SH;
  localparam int CW     = HW + 1;
  localparam logic [EW-1:0] EXT_HIT = EW'(FALL_STROBE ? 0 : EXT_MOD / 2);
  localparam logic [EW-1:0] EXT_PRE = EW'(EXT_MOD - 1);

  logic          active_q, lvl_q, strobe_q;
  logic [HW-1:0] half_q, half_d;
  logic [CW-1:0] cnt_q, cnt_nxt, per;
  logic [EW-1:0] ext_q, ext_nxt;
  logic [DIV_W-1:0] div_eff;
  logic          lvl_nxt, edge_hit, start_fire;

  assign div_eff    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign half_d     = sync_mode_i ? HW'(div_eff) : (HW'(div_eff) << OVS_SH);
  assign per        = {half_q, 1'b0};
  assign cnt_nxt    = (cnt_q == per - CW'(1)) ? '0 : cnt_q + CW'(1);
  assign lvl_nxt    = cnt_nxt >= {1'b0, half_q};
  assign edge_hit   = FALL_STROBE ? (lvl_q & ~lvl_nxt) : (~lvl_q & lvl_nxt);
  assign ext_nxt    = ext_q + EW'(1);
  assign start_fire = start_i & ~active_q & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      lvl_q    <= 1'b1;
      strobe_q <= 1'b0;
      half_q   <= HW'(1);
      cnt_q    <= '0;
      ext_q    <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (stop_i) begin
        active_q <= 1'b0;
        lvl_q    <= 1'b1;
      end else if (start_fire) begin
        active_q <= 1'b1;
        half_q   <= half_d;
        cnt_q    <= '0;
        ext_q    <= EXT_PRE;
        if (!ext_mode_i) begin
          lvl_q    <= 1'b0;
          strobe_q <= FALL_STROBE & lvl_q;
        end
      end else if (active_q) begin
        if (ext_mode_i) begin
          if (ext_rise_i) begin
            ext_q    <= ext_nxt;
            strobe_q <= (ext_nxt == EXT_HIT);
          end
        end else begin
          cnt_q    <= cnt_nxt;
          lvl_q    <= lvl_nxt;
          strobe_q <= edge_hit;
        end
      end
    end
  end

  assign active_o = active_q;
  assign lvl_o    = lvl_q;
  assign strobe_o = strobe_q;

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !ext_mode_i) |-> (cnt_q < per)); // R2
  AST_RESTART_KEEPS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && start_i && !stop_i && !ext_mode_i && cnt_q != per - CW'(1)) |=> (cnt_q != '0)); // R4
  AST_STROBE_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> active_q); // R8
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q); // R10
endmodule

// File: rtl/sci_bitclk_gen.sv
module sci_bitclk_gen
  import sci_clk_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_MOD     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_start_i,
  input  logic             tx_stop_i,
  input  logic             rx_start_i,
  input  logic             rx_stop_i,
  input  logic             ext_clk_i,
  output logic             tx_shift_o,
  output logic             rx_sample_o,
  output logic             clk_pin_o,
  output logic             clk_pin_oe_o
);
  localparam int NDIR = 2;

  sci_mode_e mode;
  logic ext_rise, ext_mode, sync_mode;
  logic [NDIR-1:0] start_v, stop_v, active_v, lvl_v, strobe_v;

  assign mode      = sci_mode_e'(mode_i);
  assign ext_mode  = (mode == MODE_EXT_ASYNC);
  assign sync_mode = (mode == MODE_INT_SYNC_OUT);
  assign start_v   = {rx_start_i, tx_start_i};
  assign stop_v    = {rx_stop_i, tx_stop_i};

  sci_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .rise_o (ext_rise)
  );

  // index 0 = transmit (falling edge), 1 = receive (rising edge)
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    sci_dir_clk #(
      .DIV_W      (DIV_W),
      .EXT_MOD    (EXT_MOD),
      .FALL_STROBE(g == 0)
    ) u_dir (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_v[g]),
      .stop_i     (stop_v[g]),
      .ext_mode_i (ext_mode),
      .sync_mode_i(sync_mode),
      .div_i      (div_i),
      .ext_rise_i (ext_rise),
      .active_o   (active_v[g]),
      .lvl_o      (lvl_v[g]),
      .strobe_o   (strobe_v[g])
    );
  end

  always_comb begin
    clk_pin_oe_o = 1'b0;
    clk_pin_o    = 1'b1;
    unique case (mode)
      MODE_INT_ASYNC_OUT: begin
        clk_pin_oe_o = 1'b1;
        clk_pin_o    = active_v[0] ? lvl_v[0] : lvl_v[1];
      end
      MODE_INT_SYNC_OUT: begin
        clk_pin_oe_o = 1'b1;
        clk_pin_o    = lvl_v[0];
      end
      default: ;
    endcase
  end

  assign tx_shift_o  = strobe_v[0];
  assign rx_sample_o = strobe_v[1];

  AST_PIN_RELEASED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_pin_oe_o |-> clk_pin_o); // R7
  AST_SYNC_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode && !active_v[0]) |-> clk_pin_o); // R8
endmodule

// File: tb/tb_sci_bitclk_gen.sv
module tb_sci_bitclk_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] div_i = 16'd1;
  logic tx_start_i = 0, tx_stop_i = 0, rx_start_i = 0, rx_stop_i = 0, ext_clk_i = 0;
  logic tx_shift_o, rx_sample_o, clk_pin_o, clk_pin_oe_o;

  int n_chk = 0, n_bad = 0;
  int tx_seen, rx_seen;

  always #5 clk_i = ~clk_i;

  sci_bitclk_gen dut (.*);

  // {mode, divider}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 16'd1}, {2'd0, 16'd2}, {2'd1, 16'd1},
    {2'd1, 16'd0}, {2'd2, 16'd1}, {2'd2, 16'd3}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic stop_all();
    tx_stop_i = 1; rx_stop_i = 1;
    tick();
    tx_stop_i = 0; rx_stop_i = 0;
  endtask

  task automatic ext_pulse();
    tx_seen = 0; rx_seen = 0;
    ext_clk_i = 1;
    repeat (4) begin tick(); tx_seen += int'(tx_shift_o); rx_seen += int'(rx_sample_o); end
    ext_clk_i = 0;
    repeat (4) begin tick(); tx_seen += int'(tx_shift_o); rx_seen += int'(rx_sample_o); end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 tx", int'(tx_shift_o), 0);
    check("R1 rx", int'(rx_sample_o), 0);
    check("R1 pin", int'(clk_pin_o), 1);
    rst_ni = 1;
    tick();
    check("R1 oe", int'(clk_pin_oe_o), 0);

    // table walk: R2, R3, R7, R8, R9 (div 0)
    for (int v = 0; v < 6; v++) begin
      int d, h, p, m;
      string tag;
      m = int'(VEC[v][17:16]);
      mode_i = VEC[v][17:16];
      div_i  = VEC[v][15:0];
      d = (div_i == 0) ? 1 : int'(div_i);
      h = (m == 2) ? d : 8 * d;
      p = 2 * h;
      tag = (m == 2) ? "R3" : ((div_i == 0) ? "R9" : "R2");
      tx_start_i = 1; rx_start_i = 1;
      tick();
      tx_start_i = 0; rx_start_i = 0;
      for (int k = 0; k <= 2 * p + 1; k++) begin
        if (k > 0) tick();
        check({tag, " tx"}, int'(tx_shift_o), int'(k % p == 0));
        check({tag, " rx"}, int'(rx_sample_o), int'(k % p == h));
        check("R7 oe", int'(clk_pin_oe_o), int'(m != 0));
        check("R7 pin", int'(clk_pin_o), (m == 0) ? 1 : int'((k % p) >= h));
      end
      stop_all();
      for (int k = 0; k < p; k++) begin
        check("R8 tx", int'(tx_shift_o), 0);
        check("R8 rx", int'(rx_sample_o), 0);
        check("R8 pin", int'(clk_pin_o), 1);
        tick();
      end
    end

    // R4 restart ignored, R9 divider change ignored
    mode_i = 2'd0; div_i = 16'd1;
    tx_start_i = 1; tick(); tx_start_i = 0;
    for (int k = 0; k <= 34; k++) begin
      if (k > 0) tick();
      if (k == 6) tx_start_i = 0;
      check("R4 tx phase", int'(tx_shift_o), int'(k % 16 == 0));
      if (k == 3) div_i = 16'd5; // R9
      if (k == 5) tx_start_i = 1;
    end
    stop_all();
    div_i = 16'd1;

    // R5 independent phases, coincident strobes
    rx_start_i = 1; tick(); rx_start_i = 0;
    for (int k = 0; k <= 26; k++) begin
      if (k > 0) tick();
      if (k == 8) tx_start_i = 0;
      check("R5 rx", int'(rx_sample_o), int'(k % 16 == 8));
      check("R5 tx", int'(tx_shift_o), int'(k >= 8 && (k - 8) % 16 == 0));
      if (k == 7) tx_start_i = 1;
    end
    stop_all();

    // R8 stop wins over start
    tx_start_i = 1; tx_stop_i = 1; tick(); tx_start_i = 0; tx_stop_i = 0;
    for (int k = 0; k < 20; k++) begin
      check("R8 start+stop", int'(tx_shift_o), 0);
      tick();
    end

    // R6 external 16x clock
    mode_i = 2'd3;
    ext_pulse();
    check("R6 inactive tx", tx_seen, 0);
    check("R6 inactive rx", rx_seen, 0);
    tx_start_i = 1; rx_start_i = 1; tick(); tx_start_i = 0; rx_start_i = 0;
    for (int n = 1; n <= 18; n++) begin
      ext_pulse();
      check("R6 R10 tx", tx_seen, int'(n == 1 || n == 17));
      check("R6 R10 rx", rx_seen, int'(n == 9));
      check("R7 ext oe", int'(clk_pin_oe_o), 0);
    end
    stop_all();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule